// File: doc/BRIEF.md
# SMBus Host Command Engine

This block is the register-facing half of an SMBus host controller. Software programs an 8-bit register file: target address with direction bit, command byte, two data bytes, a control register and a 32-byte block buffer. Software then writes the start bit. A sequencer carries out the selected SMBus protocol as a series of single-cycle accesses on a simple target request port. Each access carries the 7-bit target address, a target register index, a write flag and write data. The target answers in the same cycle with an acknowledge and read data. Bit-level bus signalling happens outside this block.

The sequencer is a four-state machine:
- `S_IDLE` waits for start. It leaves on `start` to `S_WR` when the protocol has a write phase, to `S_RD` when it has only a read phase, and to `S_END` when the request is rejected or has nothing to move.
- `S_WR` issues one write access per cycle. It goes to `S_RD` after the last write when a read phase follows, to `S_END` otherwise, and to `S_END` at once on a missing acknowledge.
- `S_RD` issues one read access per cycle. It goes to `S_END` after the last read or on a missing acknowledge.
- `S_END` reports completion for one cycle and returns to `S_IDLE`.

On completion the block records done, device-error or rejected status. It can hold an interrupt line high until software clears that status.

Top module: `smb_host_engine`

Register offsets on `reg_addr`:

| Offset | Register | Contents |
|---|---|---|
| 0 | status | bit0 busy (read-only), bit1 done, bit2 device error, bit3 rejected |
| 1 | control | bit0 interrupt enable, bits3:1 protocol, bit6 start |
| 2 | command byte | |
| 3 | target | bits7:1 address, bit0 = 1 read / 0 write |
| 4 | data 0 | |
| 5 | data 1 | |
| 6 | block buffer port | |
| 7 | auxiliary | plain storage |

Protocol codes in control bits3:1:

| Code | Protocol |
|---|---|
| 0 | quick |
| 1 | byte |
| 2 | byte data |
| 3 | word data |
| 4 | process call |
| 5 | block |
| 6 | block process call |
| 7 | reserved |

## Requirements
- R1: After reset every register reads 0, `irq` is 0 and `tgt_req` is 0.
- R2: Writing status clears exactly the done, device-error and rejected bits written as 1; the other bits keep their value.
- R3: Control bit6 (start) always reads back as 0; writing it as 1 launches the protocol in control bits3:1 and status bit0 (busy) reads 1 until completion, then done (bit1) is set on success.
- R4: A start written while busy is ignored: the running transaction keeps its latched protocol, and no extra accesses occur.
- R5: Each write to offset 6 stores the byte at the buffer pointer and advances it; each read returns the byte at the pointer and advances it; the pointer wraps after 32.
- R6: Any read of the control register resets the buffer pointer to 0.
- R7: Byte (code 1) accesses target index 0, sending the command byte on write and filling data 0 on read. Byte data (code 2) moves data 0 to or from index = command byte. Word data (code 3) moves data 0 to or from that index and data 1 to or from the index after it.
- R8: Process call (code 4) writes data 0 to index C and data 1 to C+1, then reads C into data 1 and C+1 into data 0.
- R9: Block write (code 5, write) sends the first N buffer bytes (N = data 0) to indices C..C+N-1; N above 32 is rejected (status bit3) with no access.
- R10: Block read (code 5, read) fills all 32 buffer entries from indices C..C+31 and sets data 0 to 32.
- R11: Block process call (code 6) writes N buffer bytes to C..C+N-1, then fills buffer entry i from index C+N-1-i. It then sets data 0 to N and resets the pointer. N above 16 is rejected.
- R12: An access without acknowledge sets status bit2 (device error), not done, and no further access is issued for that transaction.
- R13: `irq` is high exactly while control bit0 is 1 and any of status bits 1..3 is set, including after an error.
- R14: Process call or block process call with the read direction, and protocol code 7, are rejected (status bit3) with no access and no data change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on buffer pointer) |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| tgt_req | output | 1 | Target access valid this cycle |
| tgt_we | output | 1 | Access is a write |
| tgt_addr | output | 7 | Target bus address |
| tgt_idx | output | 8 | Target register index |
| tgt_wdata | output | 8 | Write data to target |
| tgt_rdata | input | 8 | Read data from target, same cycle |
| tgt_ack | input | 1 | Target acknowledged, same cycle |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets these corner cases:
- Index order in the process-call swap and the reversed refill of block process call. A design that mixed up C and C+1, or read in forward order, would leave data 0 and data 1, or the buffer, in the wrong order.
- The two count limits, 33 for block write and 17 for block process call. An off-by-one design would move bytes, or raise no rejected flag.
- A missing acknowledge in the middle of a word write. A design that carried on would raise the access count above one.
- Pointer wrap after 32 and pointer reset on a control read. Each would return the wrong buffer byte if mishandled.
- A second start during a long block write. It must neither restart the sequencer nor swap the protocol.

Randomized byte-data and word-data traffic in both directions covers the plain mapping.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    typedef enum logic [2:0] {
        P_QUICK = 3'd0,
        P_BYTE  = 3'd1,
        P_BDATA = 3'd2,
        P_WORD  = 3'd3,
        P_PROC  = 3'd4,
        P_BLOCK = 3'd5,
        P_BPROC = 3'd6,
        P_RSVD  = 3'd7
    } proto_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_WR,
        S_RD,
        S_END
    } seq_state_e;

    localparam logic [2:0] A_STAT = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_CMD  = 3'd2;
    localparam logic [2:0] A_TGT  = 3'd3;
    localparam logic [2:0] A_D0   = 3'd4;
    localparam logic [2:0] A_D1   = 3'd5;
    localparam logic [2:0] A_BUF  = 3'd6;
    localparam logic [2:0] A_AUX  = 3'd7;

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter int DEPTH = 32,
    localparam int BW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          h_we,
    input  logic          h_rd,
    input  logic          h_clr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    output logic [BW-1:0] h_ptr,
    input  logic [BW-1:0] e_addr,
    input  logic          e_we,
    input  logic [7:0]    e_wdata,
    output logic [7:0]    e_rdata
);

    logic [7:0]    mem [DEPTH];
    logic [BW-1:0] ptr;

    assign h_rdata = mem[ptr];
    assign e_rdata = mem[e_addr];
    assign h_ptr   = ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else begin
            if (e_we) mem[e_addr] <= e_wdata;
            else if (h_we) mem[ptr] <= h_wdata;
            if (h_clr) ptr <= '0;
            else if (h_we || h_rd) ptr <= ptr + 1'b1;
        end
    end

endmodule

// File: rtl/smb_host_seq.sv
module smb_host_seq
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int BW       = $clog2(BUF_DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  proto_e        proto_i,
    input  logic          rd_dir,
    input  logic [7:0]    base_i,
    input  logic [7:0]    d0,
    input  logic [7:0]    d1,
    output logic          busy,
    output logic          tgt_req,
    output logic          tgt_we,
    output logic [7:0]    tgt_idx,
    output logic [7:0]    tgt_wdata,
    input  logic          tgt_ack,
    input  logic [7:0]    tgt_rdata,
    output logic [BW-1:0] buf_addr,
    output logic          buf_we,
    output logic [7:0]    buf_wdata,
    input  logic [7:0]    buf_rdata,
    output logic          d0_we,
    output logic [7:0]    d0_wdata,
    output logic          d1_we,
    output logic [7:0]    d1_wdata,
    output logic          fin,
    output logic          fin_err,
    output logic          fin_rej,
    output logic          ptr_clr
);

    localparam logic [7:0] FULL8 = 8'(BUF_DEPTH);
    localparam logic [7:0] HALF8 = 8'(BUF_DEPTH / 2);

    seq_state_e state;
    proto_e     proto_q;
    logic [7:0] base_q, nwr_q, nrd_q, cnt;
    logic       err_q, rej_q;
    logic       dec_rej;
    logic [7:0] dec_nwr, dec_nrd;

    // protocol decode: number of write and read accesses, or rejection
    always_comb begin
        dec_rej = 1'b0;
        dec_nwr = 8'd0;
        dec_nrd = 8'd0;
        unique case (proto_i)
            P_QUICK: dec_nrd = 8'd1;
            P_BYTE, P_BDATA: if (rd_dir) dec_nrd = 8'd1; else dec_nwr = 8'd1;
            P_WORD:  if (rd_dir) dec_nrd = 8'd2; else dec_nwr = 8'd2;
            P_PROC:  if (rd_dir) dec_rej = 1'b1;
                     else begin dec_nwr = 8'd2; dec_nrd = 8'd2; end
            P_BLOCK: if (rd_dir) dec_nrd = FULL8;
                     else if (d0 > FULL8) dec_rej = 1'b1;
                     else dec_nwr = d0;
            P_BPROC: if (rd_dir || d0 > HALF8) dec_rej = 1'b1;
                     else begin dec_nwr = d0; dec_nrd = d0; end
            P_RSVD:  dec_rej = 1'b1;
        endcase
    end

    // state register and transaction context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            proto_q <= P_QUICK;
            base_q  <= '0;
            nwr_q   <= '0;
            nrd_q   <= '0;
            cnt     <= '0;
            err_q   <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    proto_q <= proto_i;
                    base_q  <= base_i;
                    nwr_q   <= dec_nwr;
                    nrd_q   <= dec_nrd;
                    cnt     <= '0;
                    err_q   <= 1'b0;
                    rej_q   <= dec_rej;
                    if (dec_rej)            state <= S_END;
                    else if (dec_nwr != 0)  state <= S_WR;
                    else if (dec_nrd != 0)  state <= S_RD;
                    else                    state <= S_END;
                end
                S_WR: begin
                    if (!tgt_ack) begin
                        err_q <= 1'b1;
                        state <= S_END;
                    end else if (cnt == nwr_q - 8'd1) begin
                        cnt   <= '0;
                        state <= (nrd_q != 0) ? S_RD : S_END;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                S_RD: begin
                    if (!tgt_ack) begin
                        err_q <= 1'b1;
                        state <= S_END;
                    end else if (cnt == nrd_q - 8'd1) begin
                        cnt   <= '0;
                        state <= S_END;
                    end else begin
                        cnt <= cnt + 8'd1;
                    end
                end
                S_END: state <= S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        tgt_req   = 1'b0;
        tgt_we    = 1'b0;
        tgt_idx   = base_q + cnt;
        tgt_wdata = 8'h00;
        buf_addr  = cnt[BW-1:0];
        buf_we    = 1'b0;
        buf_wdata = tgt_rdata;
        d0_we     = 1'b0;
        d0_wdata  = tgt_rdata;
        d1_we     = 1'b0;
        d1_wdata  = tgt_rdata;
        fin       = 1'b0;
        fin_err   = 1'b0;
        fin_rej   = 1'b0;
        ptr_clr   = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_WR: begin
                tgt_req = 1'b1;
                tgt_we  = 1'b1;
                case (proto_q)
                    P_BYTE: begin tgt_idx = 8'h00; tgt_wdata = base_q; end
                    P_BLOCK, P_BPROC: tgt_wdata = buf_rdata;
                    default: tgt_wdata = (cnt == 8'd0) ? d0 : d1;
                endcase
            end
            S_RD: begin
                tgt_req = 1'b1;
                case (proto_q)
                    P_QUICK: tgt_idx = 8'h00;
                    P_BYTE: begin tgt_idx = 8'h00; d0_we = tgt_ack; end
                    P_BDATA: d0_we = tgt_ack;
                    P_WORD: begin
                        d0_we = tgt_ack && (cnt == 8'd0);
                        d1_we = tgt_ack && (cnt != 8'd0);
                    end
                    P_PROC: begin
                        d1_we = tgt_ack && (cnt == 8'd0);
                        d0_we = tgt_ack && (cnt != 8'd0);
                    end
                    P_BLOCK: buf_we = tgt_ack;
                    P_BPROC: begin
                        tgt_idx = base_q + nwr_q - 8'd1 - cnt;
                        buf_we  = tgt_ack;
                    end
                    default: ;
                endcase
            end
            S_END: begin
                fin     = 1'b1;
                fin_err = err_q;
                fin_rej = rej_q;
                if (!err_q && !rej_q && nrd_q != 0 &&
                    (proto_q == P_BLOCK || proto_q == P_BPROC)) begin
                    d0_we    = 1'b1;
                    d0_wdata = nrd_q;
                end
                ptr_clr = !err_q && !rej_q && (proto_q == P_BPROC);
            end
        endcase
    end

    assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_req && !tgt_ack |=> !tgt_req);

    assert_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WR || state == S_RD) && start |=> $stable(proto_q));

endmodule

// File: rtl/smb_host_engine.sv
module smb_host_engine
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    localparam int BW       = $clog2(BUF_DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       tgt_req,
    output logic       tgt_we,
    output logic [6:0] tgt_addr,
    output logic [7:0] tgt_idx,
    output logic [7:0] tgt_wdata,
    input  logic [7:0] tgt_rdata,
    input  logic       tgt_ack,
    output logic       irq
);

    logic       st_done, st_err, st_rej;
    logic       irq_en;
    proto_e     proto;
    logic [7:0] cmd_r, tgt_r, d0_r, d1_r, aux_r;

    logic          seq_busy, seq_fin, seq_ferr, seq_frej, seq_pclr;
    logic          d0_we, d1_we, sbuf_we;
    logic [7:0]    d0_wd, d1_wd, sbuf_wd, sbuf_rd, hbuf_rd;
    logic [BW-1:0] sbuf_addr, buf_ptr;

    wire wr_ctrl = reg_wr && (reg_addr == A_CTRL);
    wire start   = wr_ctrl && reg_wdata[6];

    assign tgt_addr = tgt_r[7:1];
    assign irq      = irq_en && (st_done || st_err || st_rej);

    smb_blk_buf #(.DEPTH(BUF_DEPTH)) u_buf (
        .clk, .rst_n,
        .h_we    (reg_wr && reg_addr == A_BUF),
        .h_rd    (reg_rd && reg_addr == A_BUF),
        .h_clr   ((reg_rd && reg_addr == A_CTRL) || seq_pclr),
        .h_wdata (reg_wdata),
        .h_rdata (hbuf_rd),
        .h_ptr   (buf_ptr),
        .e_addr  (sbuf_addr),
        .e_we    (sbuf_we),
        .e_wdata (sbuf_wd),
        .e_rdata (sbuf_rd)
    );

    smb_host_seq #(.BUF_DEPTH(BUF_DEPTH)) u_seq (
        .clk, .rst_n,
        .start     (start),
        .proto_i   (proto_e'(reg_wdata[3:1])),
        .rd_dir    (tgt_r[0]),
        .base_i    (cmd_r),
        .d0        (d0_r),
        .d1        (d1_r),
        .busy      (seq_busy),
        .tgt_req, .tgt_we, .tgt_idx, .tgt_wdata, .tgt_ack, .tgt_rdata,
        .buf_addr  (sbuf_addr),
        .buf_we    (sbuf_we),
        .buf_wdata (sbuf_wd),
        .buf_rdata (sbuf_rd),
        .d0_we, .d0_wdata (d0_wd),
        .d1_we, .d1_wdata (d1_wd),
        .fin       (seq_fin),
        .fin_err   (seq_ferr),
        .fin_rej   (seq_frej),
        .ptr_clr   (seq_pclr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {st_done, st_err, st_rej} <= '0;
            irq_en <= 1'b0;
            proto  <= P_QUICK;
            cmd_r  <= '0;
            tgt_r  <= '0;
            d0_r   <= '0;
            d1_r   <= '0;
            aux_r  <= '0;
        end else begin
            if (reg_wr && reg_addr == A_STAT) begin
                if (reg_wdata[1]) st_done <= 1'b0;
                if (reg_wdata[2]) st_err  <= 1'b0;
                if (reg_wdata[3]) st_rej  <= 1'b0;
            end
            if (seq_fin) begin
                if (!seq_ferr && !seq_frej) st_done <= 1'b1;
                if (seq_ferr) st_err <= 1'b1;
                if (seq_frej) st_rej <= 1'b1;
            end
            if (wr_ctrl) begin
                irq_en <= reg_wdata[0];
                proto  <= proto_e'(reg_wdata[3:1]);
            end
            if (reg_wr && reg_addr == A_CMD) cmd_r <= reg_wdata;
            if (reg_wr && reg_addr == A_TGT) tgt_r <= reg_wdata;
            if (reg_wr && reg_addr == A_AUX) aux_r <= reg_wdata;
            if (d0_we) d0_r <= d0_wd;
            else if (reg_wr && reg_addr == A_D0) d0_r <= reg_wdata;
            if (d1_we) d1_r <= d1_wd;
            else if (reg_wr && reg_addr == A_D1) d1_r <= reg_wdata;
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_STAT: reg_rdata = {4'h0, st_rej, st_err, st_done, seq_busy};
            A_CTRL: reg_rdata = {4'h0, proto, irq_en};
            A_CMD:  reg_rdata = cmd_r;
            A_TGT:  reg_rdata = tgt_r;
            A_D0:   reg_rdata = d0_r;
            A_D1:   reg_rdata = d1_r;
            A_BUF:  reg_rdata = hbuf_rd;
            A_AUX:  reg_rdata = aux_r;
        endcase
    end

    assert_ptr_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == A_CTRL |=> buf_ptr == '0);

    assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_addr == A_BUF && !seq_busy |=> buf_ptr == $past(buf_ptr) + 1'b1);

    assert_irq_on_end_R13: assert property (@(posedge clk) disable iff (!rst_n)
        seq_fin && !reg_wr |=> irq == $past(irq_en));

    assert_start_reads_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr == A_CTRL |-> !reg_rdata[6]);

endmodule

// File: tb/smb_host_engine_tb_top.sv
module smb_host_engine_tb_top;

    localparam logic [6:0] TADDR = 7'h35;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       tgt_req, tgt_we, tgt_ack;
    logic [6:0] tgt_addr;
    logic [7:0] tgt_idx, tgt_wdata, tgt_rdata;
    logic       irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    logic [7:0] tmem [256];
    logic       pk_we = 1'b0;
    logic [7:0] pk_idx = 8'h00, pk_dat = 8'h00;
    int         req_cnt = 0;
    logic       req_clr = 1'b0;

    always #5 clk = ~clk;

    smb_host_engine dut_i (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
        .tgt_req, .tgt_we, .tgt_addr, .tgt_idx, .tgt_wdata, .tgt_rdata,
        .tgt_ack, .irq
    );

    // target model: one device at TADDR with 256 byte registers
    assign tgt_ack   = tgt_req && (tgt_addr == TADDR);
    assign tgt_rdata = tmem[tgt_idx];

    always @(posedge clk) begin
        if (pk_we) tmem[pk_idx] <= pk_dat;
        else if (tgt_req && tgt_we && tgt_ack) tmem[tgt_idx] <= tgt_wdata;
        if (req_clr) req_cnt <= 0;
        else if (tgt_req) req_cnt <= req_cnt + 1;
    end

    function automatic logic [7:0] ctrl_val(input logic [2:0] p, input logic en, input logic go);
        return {1'b0, go, 2'b00, p, en};
    endfunction

    function automatic logic [7:0] bp_expect(input logic [7:0] b [4], input int i, input int n);
        return b[n - 1 - i];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic poke(input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        pk_we = 1'b1; pk_idx = i; pk_dat = d;
        @(negedge clk);
        pk_we = 1'b0;
    endtask

    task automatic clr_reqs();
        @(negedge clk); req_clr = 1'b1;
        @(negedge clk); req_clr = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 200; k++) begin
            rd(3'd0, s);
            if (!s[0]) return;
        end
    endtask

    task automatic run(input logic [2:0] p, input logic en);
        wr(3'd0, 8'h0E);
        wr(3'd1, ctrl_val(p, en, 1'b1));
        wait_idle();
    endtask

    initial begin
        logic [7:0] v, st;
        logic [7:0] b [4];
        for (int i = 0; i < 256; i++) tmem[i] = 8'h00;
        void'($urandom(32'd2468));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk(v == 8'h00, "R1 status", v, 0);
        rd(3'd1, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(3'd4, v); chk(v == 8'h00, "R1 data0", v, 0);
        chk(irq == 1'b0 && tgt_req == 1'b0, "R1 irq/req", {irq, tgt_req}, 0);

        // R5/R6 buffer port, pointer reset and wrap
        for (int i = 0; i < 32; i++) wr(3'd6, 8'(i * 3 + 1));
        rd(3'd1, v);
        for (int i = 0; i < 32; i++) begin
            rd(3'd6, v);
            chk(v == 8'(i * 3 + 1), "R5 buffer readback", v, i * 3 + 1);
        end
        rd(3'd6, v); chk(v == 8'd1, "R5 pointer wrap", v, 1);
        rd(3'd6, v); rd(3'd1, v); rd(3'd6, v);
        chk(v == 8'd1, "R6 ctrl read resets pointer", v, 1);

        wr(3'd3, {TADDR, 1'b0});

        // R7 byte write / read, R3 start reads back 0 and done set
        wr(3'd2, 8'hA5);
        run(3'd1, 1'b0);
        chk(tmem[0] == 8'hA5, "R7 byte write idx0", tmem[0], 8'hA5);
        rd(3'd0, v); chk(v == 8'h02, "R3 done after success", v, 2);
        rd(3'd1, v); chk(v[6] == 1'b0, "R3 start reads 0", v, 8'h02);
        poke(8'h00, 8'h3C);
        wr(3'd3, {TADDR, 1'b1});
        run(3'd1, 1'b0);
        rd(3'd4, v); chk(v == 8'h3C, "R7 byte read to data0", v, 8'h3C);

        // R7 random byte-data and word-data traffic
        for (int it = 0; it < 24; it++) begin
            logic [7:0] c, x0, x1, r0, r1;
            logic       word, rdir;
            c = 8'($urandom_range(8, 200)); x0 = 8'($urandom); x1 = 8'($urandom);
            word = 1'($urandom); rdir = 1'($urandom);
            wr(3'd2, c);
            wr(3'd3, {TADDR, rdir});
            if (rdir) begin
                poke(c, x0); poke(c + 8'd1, x1);
                run(word ? 3'd3 : 3'd2, 1'b0);
                rd(3'd4, r0); rd(3'd5, r1);
                chk(r0 == x0, "R7 read data0", r0, x0);
                if (word) chk(r1 == x1, "R7 word read data1", r1, x1);
            end else begin
                wr(3'd4, x0); wr(3'd5, x1);
                run(word ? 3'd3 : 3'd2, 1'b0);
                chk(tmem[c] == x0, "R7 write at C", tmem[c], x0);
                if (word) chk(tmem[c + 8'd1] == x1, "R7 word write at C+1", tmem[c + 8'd1], x1);
            end
        end

        // R8 process call swap
        wr(3'd3, {TADDR, 1'b0});
        wr(3'd2, 8'h40); wr(3'd4, 8'h11); wr(3'd5, 8'h22);
        run(3'd4, 1'b0);
        chk(tmem[8'h40] == 8'h11 && tmem[8'h41] == 8'h22, "R8 proc writes",
            {tmem[8'h40], tmem[8'h41]}, 16'h1122);
        rd(3'd4, v); chk(v == 8'h22, "R8 data0 from C+1", v, 8'h22);
        rd(3'd5, v); chk(v == 8'h11, "R8 data1 from C", v, 8'h11);

        // R14 process call with read direction and reserved code
        wr(3'd3, {TADDR, 1'b1}); wr(3'd2, 8'h50); wr(3'd4, 8'h77);
        clr_reqs();
        run(3'd4, 1'b0);
        rd(3'd0, v); chk(v == 8'h08, "R14 proc read rejected", v, 8);
        rd(3'd4, st); chk(st == 8'h77 && req_cnt == 0, "R14 no data moved", req_cnt, 0);
        run(3'd7, 1'b0);
        rd(3'd0, v); chk(v == 8'h08, "R14 reserved code rejected", v, 8);
        run(3'd6, 1'b0);
        rd(3'd0, v); chk(v == 8'h08 && req_cnt == 0, "R14 block proc read rejected", v, 8);

        // R9 block write count 5, then 33
        wr(3'd3, {TADDR, 1'b0}); wr(3'd2, 8'h80); wr(3'd4, 8'd5);
        rd(3'd1, v);
        for (int i = 0; i < 5; i++) wr(3'd6, 8'(8'hC0 + i));
        run(3'd5, 1'b0);
        for (int i = 0; i < 5; i++)
            chk(tmem[8'h80 + i] == 8'(8'hC0 + i), "R9 block write byte", tmem[8'h80 + i], 8'hC0 + i);
        chk(tmem[8'h85] == 8'h00, "R9 no byte past count", tmem[8'h85], 0);
        wr(3'd2, 8'hE0); wr(3'd4, 8'd33);
        clr_reqs();
        run(3'd5, 1'b0);
        rd(3'd0, v); chk(v == 8'h08 && req_cnt == 0, "R9 count 33 rejected", v, 8);

        // R10 block read of 32 entries
        for (int i = 0; i < 32; i++) poke(8'(8'h90 + i), 8'(8'h5A ^ i));
        wr(3'd3, {TADDR, 1'b1}); wr(3'd2, 8'h90);
        run(3'd5, 1'b0);
        rd(3'd4, v); chk(v == 8'd32, "R10 count in data0", v, 32);
        rd(3'd1, v);
        for (int i = 0; i < 32; i++) begin
            rd(3'd6, v);
            chk(v == 8'(8'h5A ^ i), "R10 block read byte", v, 8'h5A ^ i);
        end

        // R11 block process call count 4, then 17
        wr(3'd3, {TADDR, 1'b0}); wr(3'd2, 8'hA0); wr(3'd4, 8'd4);
        rd(3'd1, v);
        for (int i = 0; i < 4; i++) begin b[i] = 8'($urandom); wr(3'd6, b[i]); end
        run(3'd6, 1'b0);
        chk(tmem[8'hA3] == b[3], "R11 write phase", tmem[8'hA3], b[3]);
        rd(3'd4, v); chk(v == 8'd4, "R11 count in data0", v, 4);
        for (int i = 0; i < 4; i++) begin
            rd(3'd6, v);
            chk(v == bp_expect(b, i, 4), "R11 reversed refill", v, bp_expect(b, i, 4));
        end
        wr(3'd4, 8'd17);
        clr_reqs();
        run(3'd6, 1'b0);
        rd(3'd0, v); chk(v == 8'h08 && req_cnt == 0, "R11 count 17 rejected", v, 8);

        // R4 start while busy ignored
        wr(3'd2, 8'h00); wr(3'd4, 8'd20);
        clr_reqs();
        wr(3'd0, 8'h0E);
        wr(3'd1, ctrl_val(3'd5, 1'b0, 1'b1));
        wr(3'd1, ctrl_val(3'd3, 1'b0, 1'b1));
        wait_idle();
        chk(req_cnt == 20, "R4 second start ignored", req_cnt, 20);
        rd(3'd0, v); chk(v == 8'h02, "R4 single completion", v, 2);

        // R12 no acknowledge, R13 interrupt level, R2 write-1-to-clear
        wr(3'd3, {7'h12, 1'b0});
        clr_reqs();
        run(3'd3, 1'b1);
        rd(3'd0, v); chk(v == 8'h04, "R12 device error, no done", v, 4);
        chk(req_cnt == 1, "R12 stops after nack", req_cnt, 1);
        #1 chk(irq == 1'b1, "R13 irq on error", irq, 1);
        wr(3'd0, 8'h0A);
        rd(3'd0, v); chk(v == 8'h04, "R2 other bits kept", v, 4);
        #1 chk(irq == 1'b1, "R13 irq held", irq, 1);
        wr(3'd0, 8'h04);
        rd(3'd0, v); chk(v == 8'h00, "R2 error cleared", v, 0);
        #1 chk(irq == 1'b0, "R13 irq drops", irq, 0);
        wr(3'd3, {TADDR, 1'b0});
        run(3'd0, 1'b0);
        #1 chk(irq == 1'b0, "R13 irq masked", irq, 0);
        wr(3'd1, ctrl_val(3'd0, 1'b1, 1'b0));
        #1 chk(irq == 1'b1, "R13 irq after enable", irq, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule